// File: doc/BRIEF.md
# Breakpoint Trigger Unit

This block watches a processor's data-bus cycles and its stream of retired program-counter values, and produces a trigger when a programmed combination of conditions holds. Comparisons are masked bit by bit. An address comparator and a data comparator check each valid bus cycle. Four PC comparators share a single PC mask and check each retired PC. The comparator results are grouped into a first and a second level. The unit can fire on the first level alone, or it can use the first level to arm a second level that produces the trigger later.

Each trigger goes to one of two actions: a halt request or a debug interrupt request. Both are one-cycle registered pulses. The unit also reduces the processor's 4-bit status code to a single halted indicator. Software programs the unit through a write-only register port. That port holds the nine 32-bit match registers and one control register.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After reset every match register and the control register read as zero, so triggering is disabled, and both halt_req and dbg_irq are low.
- R2: The address condition is true in a cycle with bus_valid high when every bus_addr bit whose address-mask bit is 1 equals the same bit of the address register. Mask bits of 0 are ignored. Register index 0 holds the address and index 1 holds the address mask.
- R3: The data condition follows the same masked rule for bus_data when bus_valid is high. Register index 2 holds the data value and index 3 holds the data mask.
- R4: The PC condition is true in a cycle with pc_valid high when pc_value matches any of the four PC registers (indices 4 to 7) under the shared PC mask at index 8.
- R5: Control register index 9 selects the conditions for each level. Level 1 uses bits 2, 3 and 4, and level 2 uses bits 5, 6 and 7; within each group the order is address, data, PC. A level fires only when at least one condition is selected and every selected condition is true.
- R6: In single-level mode (control bit 1 = 0) a level-1 match produces a trigger pulse on the output in the cycle after the matching cycle. Each matching cycle produces exactly one pulse.
- R7: In dual-level mode (control bit 1 = 1) a level-1 match arms the unit, and a level-2 match in a later cycle while armed fires. A level-2 match in the same cycle as the arming match does not fire. Firing disarms the unit.
- R8: Any register write disarms the unit. A value written in a cycle is first used for comparison in the following cycle; the comparison in the write cycle still uses the old value.
- R9: Control bit 8 selects the action: 0 raises halt_req and 1 raises dbg_irq. The two are never high together.
- R10: status_halted is high exactly when cpu_status equals 4'b1111.
- R11: While control bit 0 (enable) is 0, neither halt_req nor dbg_irq is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index (0 to 9) |
| wr_data | input | 32 | Register write value |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_data | input | 32 | Bus cycle data |
| pc_valid | input | 1 | A PC was retired this clock |
| pc_value | input | 32 | Retired PC |
| cpu_status | input | 4 | Processor status code |
| halt_req | output | 1 | Halt request pulse |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| status_halted | output | 1 | Status code indicates halted |

## Verification
A trigger from a matching input cycle appears on halt_req or dbg_irq one clock later, through one register stage. status_halted follows cpu_status within the same cycle. A register write changes comparisons from the next cycle onward and disarms the unit at the edge on which it is taken. The bench drives inputs just after a falling edge and compares all three outputs with its reference model at the next falling edge. At that point the rising edge in between has already registered the result of the driven cycle. Each directed check therefore reads the outputs right after the single cycle that carries its stimulus.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned WORD = 32;
  typedef logic [WORD-1:0] word_t;

  // condition vector order: [0] address, [1] data, [2] pc
  localparam int unsigned NCOND = 3;
  typedef logic [NCOND-1:0] cond_t;

  typedef struct packed {
    logic  act_irq;  // 1: debug interrupt, 0: halt
    cond_t l2_sel;
    cond_t l1_sel;
    logic  dual;
    logic  en;
  } bkpt_ctrl_t;

  localparam int unsigned CTL_W = $bits(bkpt_ctrl_t);

  function automatic logic masked_eq(word_t value, word_t ref_v, word_t mask);
    return ((value ^ ref_v) & mask) == '0;
  endfunction

  function automatic logic level_hit(cond_t sel, cond_t hits);
    return (sel != '0) && ((hits & sel) == sel);
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int unsigned NPC = 4,
  localparam int unsigned IW = $clog2(NPC + 6)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [IW-1:0] wr_idx,
  input  word_t      wr_data,
  output word_t      addr_r,
  output word_t      amask_r,
  output word_t      data_r,
  output word_t      dmask_r,
  output word_t      pc_r [NPC],
  output word_t      pcmask_r,
  output bkpt_ctrl_t ctrl
);
  localparam int unsigned IDX_PCM = 4 + NPC;
  localparam int unsigned IDX_CTL = 5 + NPC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r   <= '0;
      amask_r  <= '0;
      data_r   <= '0;
      dmask_r  <= '0;
      pcmask_r <= '0;
      ctrl     <= '0;
    end else if (wr_en) begin
      if (wr_idx == IW'(0)) addr_r <= wr_data;
      if (wr_idx == IW'(1)) amask_r <= wr_data;
      if (wr_idx == IW'(2)) data_r <= wr_data;
      if (wr_idx == IW'(3)) dmask_r <= wr_data;
      if (wr_idx == IW'(IDX_PCM)) pcmask_r <= wr_data;
      if (wr_idx == IW'(IDX_CTL)) ctrl <= bkpt_ctrl_t'(wr_data[CTL_W-1:0]);
    end
  end

  for (genvar g = 0; g < NPC; g++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_r[g] <= '0;
      else if (wr_en && wr_idx == IW'(4 + g)) pc_r[g] <= wr_data;
    end
  end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int unsigned NPC = 4
) (
  input  logic  bus_valid,
  input  word_t bus_addr,
  input  word_t bus_data,
  input  logic  pc_valid,
  input  word_t pc_value,
  input  word_t addr_r,
  input  word_t amask_r,
  input  word_t data_r,
  input  word_t dmask_r,
  input  word_t pc_r [NPC],
  input  word_t pcmask_r,
  output cond_t hits
);
  logic [NPC-1:0] pc_hit_vec;

  for (genvar g = 0; g < NPC; g++) begin : g_pccmp
    assign pc_hit_vec[g] = masked_eq(pc_value, pc_r[g], pcmask_r);
  end

  assign hits[0] = bus_valid && masked_eq(bus_addr, addr_r, amask_r);
  assign hits[1] = bus_valid && masked_eq(bus_data, data_r, dmask_r);
  assign hits[2] = pc_valid && (|pc_hit_vec);
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  bkpt_ctrl_t ctrl,
  input  cond_t      hits,
  output logic       fire,
  output logic       armed
);
  logic lvl1, lvl2;

  assign lvl1 = level_hit(ctrl.l1_sel, hits);
  assign lvl2 = level_hit(ctrl.l2_sel, hits);
  assign fire = ctrl.en && (ctrl.dual ? (armed && lvl2) : lvl1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            armed <= 1'b0;
    else if (wr_en || fire)                armed <= 1'b0;
    else if (ctrl.en && ctrl.dual && lvl1) armed <= 1'b1;
  end
endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned NPC = 4,
  localparam int unsigned IW = $clog2(NPC + 6)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          bus_valid,
  input  logic [31:0]   bus_addr,
  input  logic [31:0]   bus_data,
  input  logic          pc_valid,
  input  logic [31:0]   pc_value,
  input  logic [3:0]    cpu_status,
  output logic          halt_req,
  output logic          dbg_irq,
  output logic          status_halted
);
  word_t      addr_r, amask_r, data_r, dmask_r, pcmask_r;
  word_t      pc_r [NPC];
  bkpt_ctrl_t ctrl;
  cond_t      hits;
  logic       fire, armed;

  bkpt_regs #(.NPC(NPC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .addr_r(addr_r), .amask_r(amask_r), .data_r(data_r), .dmask_r(dmask_r),
    .pc_r(pc_r), .pcmask_r(pcmask_r), .ctrl(ctrl)
  );

  bkpt_match #(.NPC(NPC)) u_match (
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .pc_valid(pc_valid), .pc_value(pc_value),
    .addr_r(addr_r), .amask_r(amask_r), .data_r(data_r), .dmask_r(dmask_r),
    .pc_r(pc_r), .pcmask_r(pcmask_r), .hits(hits)
  );

  bkpt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl(ctrl), .hits(hits),
    .fire(fire), .armed(armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      dbg_irq  <= 1'b0;
    end else begin
      halt_req <= fire && !ctrl.act_irq;
      dbg_irq  <= fire && ctrl.act_irq;
    end
  end

  assign status_halted = &cpu_status;
endmodule

// File: rtl/bkpt_trigger_checks.sv
module bkpt_trigger_checks
  import bkpt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       fire,
  input logic       armed,
  input bkpt_ctrl_t ctrl,
  input logic       halt_req,
  input logic       dbg_irq
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq)); // R9
  AST_HALT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl.act_irq) |=> (halt_req && !dbg_irq)); // R9
  AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl.act_irq) |=> (dbg_irq && !halt_req)); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (!halt_req && !dbg_irq)); // R11
  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !armed); // R8
  AST_DUAL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl.dual) |-> armed); // R7
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed); // R7
  AST_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.dual && ctrl.l1_sel == '0) |-> !fire); // R5
endmodule

bind bkpt_trigger_unit bkpt_trigger_checks u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fire(fire), .armed(armed),
  .ctrl(ctrl), .halt_req(halt_req), .dbg_irq(dbg_irq)
);

// File: tb/bkpt_trigger_unit_tb.sv
module bkpt_trigger_unit_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic bus_valid = 0, pc_valid = 0;
  logic [31:0] bus_addr = 0, bus_data = 0, pc_value = 0;
  logic [3:0] cpu_status = 0;
  logic halt_req, dbg_irq, status_halted;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  bkpt_trigger_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .pc_valid(pc_valid), .pc_value(pc_value), .cpu_status(cpu_status),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .status_halted(status_halted)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_reg [10];
  bit m_armed, exp_halt, exp_irq;

  function automatic bit bits_agree(logic [31:0] v, logic [31:0] r, logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (m[i] && (v[i] !== r[i])) return 0;
    return 1;
  endfunction

  function automatic bit group_ok(logic [2:0] sel, bit a, bit d, bit p);
    int picked = 0;
    bit ok = 1;
    if (sel[0]) begin picked++; if (!a) ok = 0; end
    if (sel[1]) begin picked++; if (!d) ok = 0; end
    if (sel[2]) begin picked++; if (!p) ok = 0; end
    return (picked > 0) && ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 10; k++) m_reg[k] = 0;
      m_armed = 0; exp_halt = 0; exp_irq = 0;
    end else begin
      bit a, d, p, g1, g2, trig;
      a = bus_valid && bits_agree(bus_addr, m_reg[0], m_reg[1]);
      d = bus_valid && bits_agree(bus_data, m_reg[2], m_reg[3]);
      p = 0;
      if (pc_valid)
        for (int k = 4; k < 8; k++) if (bits_agree(pc_value, m_reg[k], m_reg[8])) p = 1;
      g1 = group_ok(m_reg[9][4:2], a, d, p);
      g2 = group_ok(m_reg[9][7:5], a, d, p);
      trig = 0;
      if (m_reg[9][0]) trig = m_reg[9][1] ? (m_armed && g2) : g1;
      exp_halt = trig && !m_reg[9][8];
      exp_irq  = trig && m_reg[9][8];
      if (wr_en || trig) m_armed = 0;
      else if (m_reg[9][0] && m_reg[9][1] && g1) m_armed = 1;
      if (wr_en && wr_idx < 10) m_reg[wr_idx] = wr_data;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, logic [31:0] got, logic [31:0] want, string what);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, want);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, halt_req, exp_halt, "halt_req vs model");
    chk(cur_req, dbg_irq, exp_irq, "dbg_irq vs model");
    chk("R10", status_halted, (cpu_status == 4'hF), "status_halted vs model");
    chk("R9", halt_req & dbg_irq, 0, "both requests high");
  endtask

  task automatic wr(int idx, logic [31:0] val);
    wr_en = 1; wr_idx = 4'(idx); wr_data = val;
    cyc();
    wr_en = 0;
  endtask

  task automatic idle();
    bus_valid = 0; pc_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", halt_req, 0, "halt in reset");
    chk("R1", dbg_irq, 0, "irq in reset");
    rst_n = 1;
    // R1 / R11: all-zero registers, disabled: nothing fires even on traffic
    cur_req = "R1";
    bus_valid = 1; bus_addr = 32'h1234_5678; pc_valid = 1; pc_value = 32'h40;
    cyc(); chk("R1", halt_req | dbg_irq, 0, "trigger after reset");
    idle();

    // R2 address match
    cur_req = "R2";
    wr(0, 32'h1000_0040); wr(1, 32'hFFFF_FF00); wr(9, 32'h005);
    bus_valid = 1; bus_addr = 32'h1000_00AB; cyc(); chk("R2", halt_req, 1, "masked addr hit");
    bus_addr = 32'h1000_01AB; cyc(); chk("R6", halt_req, 0, "pulse ends, addr miss");
    bus_valid = 0; bus_addr = 32'h1000_00AB; cyc(); chk("R2", halt_req, 0, "no bus_valid");
    cur_req = "R6";
    bus_valid = 1; cyc(); chk("R6", halt_req, 1, "first of two pulses");
    cyc(); chk("R6", halt_req, 1, "second of two pulses");
    idle(); cyc(); chk("R6", halt_req, 0, "pulse ends");

    // R3 data match, interrupt action
    cur_req = "R3";
    wr(2, 32'hDEAD_BEEF); wr(3, 32'h0000_FFFF); wr(9, 32'h109);
    bus_valid = 1; bus_data = 32'h1234_BEEF; cyc();
    chk("R3", dbg_irq, 1, "masked data hit");
    chk("R9", halt_req, 0, "irq action gives no halt");
    bus_data = 32'h1234_BEEE; cyc(); chk("R3", dbg_irq, 0, "data miss");
    idle();

    // R4 PC match, any of four under shared mask
    cur_req = "R4";
    wr(4, 32'h100); wr(5, 32'h200); wr(6, 32'h300); wr(7, 32'h400);
    wr(8, 32'hFFFF_FFF0); wr(9, 32'h011);
    pc_valid = 1; pc_value = 32'h30C; cyc(); chk("R4", halt_req, 1, "third pc hit");
    pc_value = 32'h40F; cyc(); chk("R4", halt_req, 1, "fourth pc hit");
    pc_value = 32'h310; cyc(); chk("R4", halt_req, 0, "pc miss");
    pc_valid = 0; pc_value = 32'h300; cyc(); chk("R4", halt_req, 0, "no pc_valid");

    // R5 AND of selected, empty level
    cur_req = "R5";
    wr(9, 32'h00D);
    bus_valid = 1; bus_addr = 32'h1000_00AB; bus_data = 32'h0;
    cyc(); chk("R5", halt_req, 0, "only addr of addr+data");
    bus_data = 32'h0000_BEEF; cyc(); chk("R5", halt_req, 1, "addr and data");
    idle(); wr(9, 32'h001);
    bus_valid = 1; pc_valid = 1; pc_value = 32'h100;
    cyc(); chk("R5", halt_req | dbg_irq, 0, "empty level never fires");
    idle();

    // R7 dual level: L1 addr, L2 pc
    cur_req = "R7";
    wr(9, 32'h087);
    pc_valid = 1; pc_value = 32'h204; cyc(); chk("R7", halt_req, 0, "L2 before arming");
    pc_valid = 0; bus_valid = 1; bus_addr = 32'h1000_0011; cyc(); chk("R7", halt_req, 0, "arming cycle");
    idle(); cyc(); chk("R7", halt_req, 0, "armed idle");
    pc_valid = 1; pc_value = 32'h104; cyc(); chk("R7", halt_req, 1, "L2 while armed");
    cyc(); chk("R7", halt_req, 0, "disarmed after trigger");
    bus_valid = 1; cyc(); chk("R7", halt_req, 0, "L1 and L2 same cycle");
    bus_valid = 0; cyc(); chk("R7", halt_req, 1, "L2 after same-cycle arm");
    idle();

    // R8 write disarms; write takes effect next cycle
    cur_req = "R8";
    bus_valid = 1; bus_addr = 32'h1000_0011; cyc(); idle();
    wr(0, 32'h1000_0040);
    pc_valid = 1; pc_value = 32'h104; cyc(); chk("R8", halt_req, 0, "write disarmed");
    idle(); wr(9, 32'h005);
    bus_valid = 1; bus_addr = 32'h2000_0001;
    wr(0, 32'h2000_0000); chk("R8", halt_req, 0, "write cycle uses old value");
    cyc(); chk("R8", halt_req, 1, "new value next cycle");
    wr(0, 32'h3000_0000); chk("R8", halt_req, 1, "old value still matched");
    cyc(); chk("R8", halt_req, 0, "newer value misses");
    idle();

    // R11 disabled with a selected condition
    cur_req = "R11";
    wr(9, 32'h004);
    bus_valid = 1; bus_addr = 32'h3000_0000; cyc(); chk("R11", halt_req | dbg_irq, 0, "disabled");
    idle();

    // R10 status reduction
    cur_req = "R10";
    cpu_status = 4'hF; #1 chk("R10", status_halted, 1, "status 1111");
    cpu_status = 4'hE; #1 chk("R10", status_halted, 0, "status 1110");
    cpu_status = 4'h7; #1 chk("R10", status_halted, 0, "status 0111");
    cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule